// File: doc/BRIEF.md
# Burst Column Address Generator

This block sits behind the command decoder of a double-data-rate memory controller. When a read or write command is accepted, it captures the starting column address, a three-bit burst-length code and a one-bit order select. It then emits one column address per clock, one for each beat of the burst.

Every beat address stays inside an aligned block whose size is the burst length. Only the low bits inside that block change. They advance either by modular addition (sequential order) or by exclusive-or with the beat index (interleaved order). The final beat is flagged. A reserved length code yields no beats and a one-cycle error pulse. The block carries no data and no strobe timing. The consumer takes the address stream and aligns it to clock edges itself.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is held and in the first cycle after it, `beat_valid_o`, `beat_last_o` and `len_err_o` are low.
- R2: A start accepted with length code 3'b001, 3'b010 or 3'b011 gives 2, 4 or 8 beats respectively. The beats come on consecutive cycles, and the first is in the cycle after the start.
- R3: With order bit 0 (sequential), beat i carries low field (S + i) mod L, where S is the start address's low field of log2(L) bits and L is the burst length.
- R4: With order bit 1 (interleaved), beat i carries low field S XOR i over the same log2(L) bits.
- R5: Every address bit at or above position log2(L) equals the captured start address on every beat; no carry leaves the burst block.
- R6: `beat_last_o` is high only on the final beat of a burst, and `beat_valid_o` is low in the cycle after it.
- R7: A start accepted with any other length code (000, 100 to 111) produces no beat. It raises `len_err_o` for exactly the one cycle after the start.
- R8: A start is accepted only when `beat_valid_o` is low. A start raised during any beat, including the final one, is ignored: it neither lengthens nor restarts the burst and raises no error.
- R9: The address, length code and order bit are sampled only at an accepted start. Changing them during a burst does not alter its remaining beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Column command strobe |
| col_i | input | COL_W | Starting column address |
| len_code_i | input | 3 | Burst length code (001 = 2, 010 = 4, 011 = 8) |
| interleave_i | input | 1 | Order select: 0 sequential, 1 interleaved |
| beat_valid_o | output | 1 | A beat address is present |
| beat_col_o | output | COL_W | Column address of the current beat |
| beat_last_o | output | 1 | Current beat is the last of the burst |
| len_err_o | output | 1 | One-cycle pulse after a start with a reserved code |

## Verification
The bench builds the generator with a six-bit column, so the whole address space is only 64 columns. A sweep covers every start column with every legal length and both orders. That includes starts near the top of the space, where a carry out of the low field would be visible, and starts at every offset inside each aligned block. The narrow column also means each reserved code and each ignored-start case sits a few cycles from a fresh, fully checked burst.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
  // widest burst is 8 beats, so at most 3 low bits ever move
  localparam int LOW_W = 3;
  typedef logic [LOW_W-1:0] low_t;

  localparam logic [2:0] CODE_BL2 = 3'b001;
  localparam logic [2:0] CODE_BL4 = 3'b010;
  localparam logic [2:0] CODE_BL8 = 3'b011;

  function automatic logic code_legal(input logic [2:0] code);
    return (code == CODE_BL2) || (code == CODE_BL4) || (code == CODE_BL8);
  endfunction

  // mask of the address bits that move during the burst (length - 1)
  function automatic low_t code_mask(input logic [2:0] code);
    case (code)
      CODE_BL2: return low_t'(3'b001);
      CODE_BL4: return low_t'(3'b011);
      CODE_BL8: return low_t'(3'b111);
      default:  return low_t'(3'b000);
    endcase
  endfunction

  // sequential: add inside the masked field, bits outside the mask untouched
  function automatic low_t seq_low(input low_t base, input low_t beat, input low_t mask);
    low_t sum;
    sum = base + beat;
    return (sum & mask) | (base & ~mask);
  endfunction

  // interleaved: beat index never exceeds mask, so XOR stays in the field
  function automatic low_t ilv_low(input low_t base, input low_t beat);
    return base ^ beat;
  endfunction
endpackage

// File: rtl/bcg_len_decode.sv
module bcg_len_decode
  import bcg_pkg::*;
(
  input  logic [2:0] code_i,
  output logic       legal_o,
  output low_t       mask_o
);
  always_comb begin
    legal_o = code_legal(code_i);
    mask_o  = code_mask(code_i);
  end
endmodule

// File: rtl/bcg_beat_ctrl.sv
module bcg_beat_ctrl
  import bcg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic go_i,
  input  low_t mask_i,
  output logic busy_o,
  output low_t beat_o,
  output low_t mask_o,
  output logic last_o
);
  logic busy_q;
  low_t beat_q;
  low_t mask_q;

  assign last_o = busy_q && (beat_q == mask_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      beat_q <= '0;
      mask_q <= '0;
    end else if (go_i) begin
      busy_q <= 1'b1;
      beat_q <= '0;
      mask_q <= mask_i;
    end else if (busy_q) begin
      if (last_o) begin
        busy_q <= 1'b0;
        beat_q <= '0;
      end else begin
        beat_q <= beat_q + low_t'(1);
      end
    end
  end

  assign busy_o = busy_q;
  assign beat_o = beat_q;
  assign mask_o = mask_q;
endmodule

// File: rtl/bcg_addr_calc.sv
module bcg_addr_calc
  import bcg_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic [COL_W-1:0] base_i,
  input  low_t             beat_i,
  input  low_t             mask_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] addr_o
);
  localparam int UP_W = COL_W - LOW_W;

  low_t base_low;
  low_t new_low;

  assign base_low = base_i[LOW_W-1:0];
  assign new_low  = ilv_i ? ilv_low(base_low, beat_i) : seq_low(base_low, beat_i, mask_i);

  generate
    if (UP_W > 0) begin : g_upper
      assign addr_o = {base_i[COL_W-1:LOW_W], new_low};
    end else begin : g_narrow
      assign addr_o = new_low[COL_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import bcg_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [2:0]       len_code_i,
  input  logic             interleave_i,
  output logic             beat_valid_o,
  output logic [COL_W-1:0] beat_col_o,
  output logic             beat_last_o,
  output logic             len_err_o
);
  // named events for the checker
  logic accept_w;
  logic go_w;
  logic reject_w;

  logic legal_w;
  low_t mask_w;
  logic busy_w;
  low_t beat_w;
  low_t run_mask_w;
  logic last_w;

  logic [COL_W-1:0] col_q;
  logic             ilv_q;
  logic             err_q;

  bcg_len_decode u_dec (
    .code_i (len_code_i),
    .legal_o(legal_w),
    .mask_o (mask_w)
  );

  assign accept_w = start_i && !busy_w;
  assign go_w     = accept_w && legal_w;
  assign reject_w = accept_w && !legal_w;

  bcg_beat_ctrl u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .go_i  (go_w),
    .mask_i(mask_w),
    .busy_o(busy_w),
    .beat_o(beat_w),
    .mask_o(run_mask_w),
    .last_o(last_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_q <= '0;
      ilv_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      err_q <= reject_w;
      if (go_w) begin
        col_q <= col_i;
        ilv_q <= interleave_i;
      end
    end
  end

  bcg_addr_calc #(.COL_W(COL_W)) u_addr (
    .base_i(col_q),
    .beat_i(beat_w),
    .mask_i(run_mask_w),
    .ilv_i (ilv_q),
    .addr_o(beat_col_o)
  );

  assign beat_valid_o = busy_w;
  assign beat_last_o  = last_w;
  assign len_err_o    = err_q;
endmodule

// File: rtl/bcg_checks.sv
module bcg_checks #(
  parameter int COL_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [2:0]       len_code_i,
  input logic             beat_valid_o,
  input logic [COL_W-1:0] beat_col_o,
  input logic             beat_last_o,
  input logic             len_err_o,
  input logic             go_w,
  input logic             reject_w
);
  logic code_bad;
  assign code_bad = (len_code_i == 3'b000) || (len_code_i[2] == 1'b1);

  assert_last_in_burst_R6: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last_o |-> beat_valid_o);

  assert_gap_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last_o |=> !beat_valid_o);

  assert_burst_continues_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid_o && !beat_last_o) |=> beat_valid_o);

  assert_begin_after_go_R2: assert property (@(posedge clk) disable iff (!rst_n)
    go_w |=> (beat_valid_o && !len_err_o));

  assert_upper_fixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid_o && !beat_last_o) |=> $stable(beat_col_o[COL_W-1:3]));

  assert_reserved_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !beat_valid_o && code_bad) |=> (len_err_o && !beat_valid_o));

  assert_err_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reject_w |=> len_err_o);

  assert_busy_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && beat_valid_o) |=> !len_err_o);

  assert_no_spurious_begin_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!beat_valid_o && !go_w) |=> !beat_valid_o);
endmodule

bind burst_col_gen bcg_checks #(.COL_W(COL_W)) u_checks (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .len_code_i  (len_code_i),
  .beat_valid_o(beat_valid_o),
  .beat_col_o  (beat_col_o),
  .beat_last_o (beat_last_o),
  .len_err_o   (len_err_o),
  .go_w        (go_w),
  .reject_w    (reject_w)
);

// File: tb/sim_burst_col_gen.sv
`timescale 1ns/1ps
module sim_burst_col_gen;
  localparam int CW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [CW-1:0] col_i = '0;
  logic [2:0]    len_code_i = 3'b000;
  logic          interleave_i = 1'b0;
  logic          beat_valid_o;
  logic [CW-1:0] beat_col_o;
  logic          beat_last_o;
  logic          len_err_o;

  always #10 clk = ~clk;

  burst_col_gen #(.COL_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .col_i(col_i),
    .len_code_i(len_code_i), .interleave_i(interleave_i),
    .beat_valid_o(beat_valid_o), .beat_col_o(beat_col_o),
    .beat_last_o(beat_last_o), .len_err_o(len_err_o)
  );

  int total = 0;
  int bad = 0;
  string phase = "R2";

  // reference model: queue of expected beat addresses
  int exp_q[$];
  int exp_ilv = 0;
  bit exp_err = 1'b0;
  bit model_on = 1'b0;

  function automatic int beats_of(input int code);
    if (code == 1) return 2;
    if (code == 2) return 4;
    if (code == 3) return 8;
    return 0;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      exp_q.delete();
      exp_err = 1'b0;
    end else begin
      bit was_busy;
      was_busy = (exp_q.size() > 0);
      if (was_busy) void'(exp_q.pop_front());
      exp_err = 1'b0;
      if (start_i && !was_busy) begin
        int n;
        n = beats_of(int'(len_code_i));
        if (n == 0) exp_err = 1'b1;
        else begin
          int blk;
          int off;
          blk = int'(col_i) - (int'(col_i) % n);
          off = int'(col_i) % n;
          exp_ilv = int'(interleave_i);
          for (int i = 0; i < n; i++)
            exp_q.push_back(interleave_i ? blk + (off ^ i) : blk + ((off + i) % n));
        end
      end
    end
  end

  always @(negedge clk) begin
    if (model_on) begin
      bit ev;
      ev = (exp_q.size() > 0);
      check(beat_valid_o == ev, {phase, " R2 valid"}, int'(beat_valid_o), int'(ev));
      check(beat_last_o == (exp_q.size() == 1), {phase, " R6 last"}, int'(beat_last_o),
            int'(exp_q.size() == 1));
      check(len_err_o == exp_err, {phase, " R7 err"}, int'(len_err_o), int'(exp_err));
      if (ev) begin
        int ea;
        ea = exp_q[0];
        if ((int'(beat_col_o) >> 3) != (ea >> 3))
          check(1'b0, {phase, " R5 upper"}, int'(beat_col_o), ea);
        else
          check(int'(beat_col_o) == ea, exp_ilv != 0 ? {phase, " R4 addr"} : {phase, " R3 addr"},
                int'(beat_col_o), ea);
      end
    end
  end

  task automatic issue(input int col, input int code, input bit ilv);
    start_i = 1'b1;
    col_i = CW'(col);
    len_code_i = 3'(code);
    interleave_i = ilv;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic drain();
    while (beat_valid_o) @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    bad++;
    total++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int vcount;
    @(negedge clk);
    @(negedge clk);
    // R1 reset state
    check(!beat_valid_o && !beat_last_o && !len_err_o, "R1 reset", int'(beat_valid_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!beat_valid_o && !len_err_o, "R1 after reset", int'(beat_valid_o), 0);
    model_on = 1'b1;

    // R2 R3 R4 R5: exhaustive sweep, back-to-back at earliest accept
    phase = "sweep";
    for (int code = 1; code <= 3; code++)
      for (int ilv = 0; ilv < 2; ilv++)
        for (int c = 0; c < 64; c++) begin
          issue(c, code, ilv[0]);
          drain();
        end

    // R7 reserved codes
    phase = "R7";
    for (int code = 0; code < 8; code++)
      if (beats_of(code) == 0) begin
        issue(37, code, 1'b0);
        check(!beat_valid_o && len_err_o, "R7 reserved", int'(len_err_o), 1);
        @(negedge clk);
        check(!len_err_o, "R7 pulse width", int'(len_err_o), 0);
      end

    // R8 start held through a whole BL4 burst, including the last beat
    phase = "R8";
    issue(13, 2, 1'b0);
    vcount = 1;
    start_i = 1'b1;
    len_code_i = 3'b011;
    while (beat_valid_o) begin
      @(negedge clk);
      if (beat_valid_o) vcount++;
      if (!beat_valid_o) start_i = 1'b0;
    end
    start_i = 1'b0;
    check(vcount == 4, "R8 beat count", vcount, 4);
    // busy start with reserved code raises no error
    issue(2, 3, 1'b1);
    issue(9, 5, 1'b0);
    check(!len_err_o, "R8 no err while busy", int'(len_err_o), 0);
    drain();
    @(negedge clk);

    // R9 inputs change during burst
    phase = "R9";
    issue(46, 3, 1'b1);
    col_i = 6'd1;
    len_code_i = 3'b001;
    interleave_i = 1'b0;
    vcount = 1;
    while (beat_valid_o) begin
      @(negedge clk);
      if (beat_valid_o) vcount++;
    end
    check(vcount == 8, "R9 length held", vcount, 8);
    @(negedge clk);
    @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule